// File: doc/BRIEF.md
# Long Message CAN Segmenter

The segmenter takes one long message, up to a configurable byte count, and turns it into a strictly ordered run of CAN frame records. A message is opened by a start pulse that carries the total length and a base identifier. The payload then arrives one byte at a time over a valid/ready handshake. Each group of up to eight bytes becomes one frame record: an identifier, a data length code and eight data lanes. The records go to a downstream transmit queue over a second valid/ready handshake.

Every frame of a message carries the same identifier, except for its two lowest bits. Those two bits hold a position code, so the receiver can tell the opening frame, the frames in between and the closing frame apart. Only one frame is ever offered at a time, and the next one is built only after the queue has taken the current one. This keeps the queue order identical to the message order.

A busy output stays high until the closing frame has been accepted. Start pulses that arrive while busy is high are ignored. A start with an empty length, or with a length above the configured maximum, produces a one-cycle error pulse and no frames.

Top module: `msg_segmenter`

## Requirements
- R1: A message of L bytes (1 to MAX_LEN) produces exactly ceil(L/8) frames. Byte 8*j+k of the message is placed in lane k of frame j, and lane k occupies frm_data[8k+7:8k].
- R2: Every frame identifier equals the base identifier captured at the start, with bits 1:0 replaced by the position code and all higher bits unchanged.
- R3: Position codes are 2'b01 for the first frame of a multi-frame message, 2'b10 for every middle frame and 2'b11 for the final frame. A message of 8 bytes or fewer is sent as a single frame coded 2'b11.
- R4: Every non-final frame has frm_dlc = 8. The final frame has frm_dlc = L - 8*(n-1), which is 1 to 8. Any lane at or above frm_dlc reads zero.
- R5: Frames leave in message order. While frm_valid is high and frm_ready is low, the identifier, length code and data hold steady, and no later frame is shown.
- R6: busy rises on the edge that accepts a valid start and falls on the edge that accepts the final frame. A start pulse while busy is high has no effect: the frames keep the captured identifier and err stays low.
- R7: A start with length 0 or length above MAX_LEN (default 100) raises err for exactly the following cycle. busy stays low and no byte or frame handshake opens.
- R8: in_ready is high only while the current frame still lacks bytes. It is low while a frame is offered and while the block is idle.
- R9: A start pulse in the same cycle as the final frame's acceptance is ignored: afterwards busy, in_ready and err remain low.
- R10: After reset, busy, err, frm_valid and in_ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_start | input | 1 | Start pulse for a new message |
| msg_len | input | LEN_W (7) | Total message length in bytes |
| msg_id | input | ID_W (29) | Base identifier |
| in_valid | input | 1 | Payload byte valid |
| in_byte | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte accepted when high with in_valid |
| frm_valid | output | 1 | Frame record offered |
| frm_ready | input | 1 | Downstream queue accepts the frame |
| frm_id | output | ID_W (29) | Frame identifier with position code in bits 1:0 |
| frm_dlc | output | 4 | Frame data length code |
| frm_data | output | 64 | Frame data, lane 0 in the low byte |
| busy | output | 1 | Message in progress |
| err | output | 1 | One-cycle pulse for a rejected length |

## Verification
Two events can fall in the same cycle: the acceptance of a message's final frame and the arrival of a new start pulse. The final frame is held back by keeping frm_ready low. The start is then raised in the very cycle frm_ready goes high. The design is correct if, afterwards, busy, in_ready and err all stay low. A second collision is also provoked: a start with an illegal length during a byte transfer in mid-message. It must leave err low and must not change the identifiers of the frames that follow.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam int DLC_W = 4;

  typedef enum logic [1:0] {
    POS_NONE  = 2'b00,
    POS_FIRST = 2'b01,
    POS_MID   = 2'b10,
    POS_LAST  = 2'b11
  } pos_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_FILL = 2'b01,
    ST_SEND = 2'b10
  } seg_state_e;

endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
#(
  parameter int ID_W      = 29,
  parameter int MAX_LEN   = 100,
  parameter int SEG_BYTES = 8,
  parameter int LEN_W     = 7,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_start,
  input  logic [LEN_W-1:0] msg_len,
  input  logic [ID_W-1:0]  msg_id,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             frm_ready,
  output logic             frm_valid,
  output logic             wr_en,
  output logic             frm_acc,
  output logic [CNT_W-1:0] fill_cnt,
  output logic [CNT_W-1:0] seg_len,
  output logic [ID_W-1:0]  base_id,
  output logic             first_seg,
  output logic             last_seg,
  output logic             busy,
  output logic             err
);

  seg_state_e       state_q, state_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;
  logic [ID_W-1:0]  id_q;
  logic             err_q, err_d;
  logic             len_ok;
  logic             load_en;
  logic             cnt_en;
  logic             rem_en;

  assign len_ok   = (msg_len != '0) && (msg_len <= LEN_W'(MAX_LEN));
  assign seg_len  = (rem_q >= LEN_W'(SEG_BYTES)) ? CNT_W'(SEG_BYTES) : CNT_W'(rem_q);
  assign last_seg = (rem_q <= LEN_W'(SEG_BYTES));
  assign in_ready  = (state_q == ST_FILL);
  assign frm_valid = (state_q == ST_SEND);
  assign wr_en     = in_ready && in_valid;
  assign frm_acc   = frm_valid && frm_ready;
  assign load_en   = (state_q == ST_IDLE) && msg_start && len_ok;
  assign cnt_en    = wr_en || frm_acc || load_en;
  assign rem_en    = frm_acc || load_en;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (msg_start) begin
          if (len_ok) begin
            state_d = ST_FILL;
            rem_d   = msg_len;
            cnt_d   = '0;
            first_d = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (wr_en) begin
          cnt_d = cnt_q + CNT_W'(1);
          if ((cnt_q + CNT_W'(1)) == seg_len) state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (frm_acc) begin
          cnt_d   = '0;
          first_d = 1'b0;
          rem_d   = rem_q - LEN_W'(seg_len);
          state_d = last_seg ? ST_IDLE : ST_FILL;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
      id_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (rem_en)  rem_q   <= rem_d;
      if (cnt_en)  cnt_q   <= cnt_d;
      if (rem_en)  first_q <= first_d;
      if (load_en) id_q    <= msg_id;
    end
  end

  assign fill_cnt  = cnt_q;
  assign base_id   = id_q;
  assign first_seg = first_q;
  assign busy      = (state_q != ST_IDLE);
  assign err       = err_q;

  // R7: an error pulse only follows a start seen while idle
  p_err_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(msg_start) && !$past(busy)));

  // R6: a start while busy never produces an error
  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && msg_start) |=> !err);

  // R6: accepting the final frame ends the message
  p_last_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_acc && last_seg) |=> !busy);

  // R8: the fill count never passes the segment size
  p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (fill_cnt < seg_len));

endmodule

// File: rtl/seg_pack.sv
module seg_pack #(
  parameter int SEG_BYTES = 8,
  parameter int CNT_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CNT_W-1:0]       wr_idx,
  input  logic [7:0]             wr_byte,
  input  logic                   clr,
  output logic [8*SEG_BYTES-1:0] data
);

  for (genvar k = 0; k < SEG_BYTES; k++) begin : g_lane
    logic [7:0] lane_q, lane_d;
    logic       lane_en;

    always_comb begin
      lane_en = clr || (wr_en && (wr_idx == CNT_W'(k)));
      lane_d  = clr ? 8'h00 : wr_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= 8'h00;
      else if (lane_en) lane_q <= lane_d;
    end

    assign data[8*k +: 8] = lane_q;

    // R4: a lane not yet written in this frame stays zero
    p_lane_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_q != 8'h00) |-> (CNT_W'(k) < wr_idx));
  end

endmodule

// File: rtl/seg_fmt.sv
module seg_fmt
  import seg_pkg::*;
#(
  parameter int ID_W  = 29,
  parameter int CNT_W = 4
) (
  input  logic [ID_W-1:0]  base_id,
  input  logic             first_seg,
  input  logic             last_seg,
  input  logic [CNT_W-1:0] seg_len,
  output logic [ID_W-1:0]  frm_id,
  output logic [DLC_W-1:0] frm_dlc
);

  pos_code_e code;

  always_comb begin
    if (last_seg)       code = POS_LAST;
    else if (first_seg) code = POS_FIRST;
    else                code = POS_MID;
  end

  assign frm_id  = (base_id & ~ID_W'(3)) | ID_W'(code);
  assign frm_dlc = DLC_W'(seg_len);

endmodule

// File: rtl/msg_segmenter.sv
module msg_segmenter
  import seg_pkg::*;
#(
  parameter int ID_W      = 29,
  parameter int MAX_LEN   = 100,
  parameter int SEG_BYTES = 8,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int CNT_W    = $clog2(SEG_BYTES + 1),
  localparam int DATA_W   = 8 * SEG_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_start,
  input  logic [LEN_W-1:0]  msg_len,
  input  logic [ID_W-1:0]   msg_id,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              frm_valid,
  input  logic              frm_ready,
  output logic [ID_W-1:0]   frm_id,
  output logic [DLC_W-1:0]  frm_dlc,
  output logic [DATA_W-1:0] frm_data,
  output logic              busy,
  output logic              err
);

  logic [1:0]       rsync_q;
  logic             rs_n;
  logic             wr_en;
  logic             frm_acc;
  logic [CNT_W-1:0] fill_cnt;
  logic [CNT_W-1:0] seg_len;
  logic [ID_W-1:0]  base_id;
  logic             first_seg;
  logic             last_seg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rs_n = rsync_q[1];

  seg_ctrl #(
    .ID_W(ID_W), .MAX_LEN(MAX_LEN), .SEG_BYTES(SEG_BYTES),
    .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rs_n),
    .msg_start(msg_start), .msg_len(msg_len), .msg_id(msg_id),
    .in_valid(in_valid), .in_ready(in_ready),
    .frm_ready(frm_ready), .frm_valid(frm_valid),
    .wr_en(wr_en), .frm_acc(frm_acc),
    .fill_cnt(fill_cnt), .seg_len(seg_len), .base_id(base_id),
    .first_seg(first_seg), .last_seg(last_seg),
    .busy(busy), .err(err)
  );

  seg_pack #(.SEG_BYTES(SEG_BYTES), .CNT_W(CNT_W)) i_pack (
    .clk(clk), .rst_n(rs_n),
    .wr_en(wr_en), .wr_idx(fill_cnt), .wr_byte(in_byte),
    .clr(frm_acc), .data(frm_data)
  );

  seg_fmt #(.ID_W(ID_W), .CNT_W(CNT_W)) i_fmt (
    .base_id(base_id), .first_seg(first_seg), .last_seg(last_seg),
    .seg_len(seg_len), .frm_id(frm_id), .frm_dlc(frm_dlc)
  );

  // R5: a stalled frame holds every field
  p_hold_r5: assert property (@(posedge clk) disable iff (!rs_n)
    (frm_valid && !frm_ready) |=>
      (frm_valid && $stable(frm_id) && $stable(frm_dlc) && $stable(frm_data)));

  // R4: the length code of an offered frame is 1 to SEG_BYTES
  p_dlc_range_r4: assert property (@(posedge clk) disable iff (!rs_n)
    frm_valid |-> ((frm_dlc != '0) && (frm_dlc <= DLC_W'(SEG_BYTES))));

  // R3: a short frame can only be the final one
  p_short_last_r3: assert property (@(posedge clk) disable iff (!rs_n)
    (frm_valid && (frm_dlc != DLC_W'(SEG_BYTES))) |-> (frm_id[1:0] == 2'b11));

endmodule

// File: tb/test_msg_segmenter.sv
`timescale 1ns/1ps
module test_msg_segmenter;

  localparam int ID_W = 29;
  localparam int MAXL = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_start = 1'b0;
  logic [6:0]  msg_len = '0;
  logic [28:0] msg_id = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_ready;
  logic        frm_valid;
  logic        frm_ready = 1'b0;
  logic [28:0] frm_id;
  logic [3:0]  frm_dlc;
  logic [63:0] frm_data;
  logic        busy;
  logic        err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  msg_segmenter i_msg_segmenter (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_len(msg_len),
    .msg_id(msg_id), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_id(frm_id), .frm_dlc(frm_dlc), .frm_data(frm_data),
    .busy(busy), .err(err)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input int m, input int i);
    return 8'((m * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic logic [28:0] mid(input int m);
    return 29'((32'h0ABC_1000 ^ (m * 32'h1357)) & 32'h1FFF_FFFF);
  endfunction

  function automatic logic [28:0] exp_id(input int m, input int n, input int j);
    logic [1:0] c;
    if (j == n - 1) c = 2'b11;
    else if (j == 0) c = 2'b01;
    else c = 2'b10;
    return {mid(m)[28:2], c};
  endfunction

  function automatic logic [63:0] exp_data(input int m, input int l, input int j);
    logic [63:0] d = '0;
    for (int k = 0; k < 8; k++)
      if (8 * j + k < l) d[8*k +: 8] = mbyte(m, 8 * j + k);
    return d;
  endfunction

  function automatic bit rdy_fn(input int mode, input int w);
    if (mode == 0) return 1'b1;
    if (mode == 1) return (w % 3) == 2;
    return w >= 4;
  endfunction

  task automatic produce(input int m, input int l, input int mode);
    bit rdy;
    bit pulse;
    for (int i = 0; i < l; i++) begin
      if (mode == 2 && (i % 5) == 1) begin
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
      end
      in_valid = 1'b1;
      in_byte  = mbyte(m, i);
      pulse = (m % 2 == 1) && (l > 8) && (i == l / 2);
      if (pulse) begin
        msg_start = 1'b1;
        msg_len   = 7'd0;
        msg_id    = ~mid(m);
      end
      forever begin
        rdy = in_ready;
        @(posedge clk); @(negedge clk);
        if (pulse) begin
          msg_start = 1'b0;
          pulse = 1'b0;
          chk(err == 1'b0, "R6 start while busy gave err", 64'(err), 64'd0);
        end
        if (rdy) break;
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic consume(input int m, input int l, input int mode);
    int n = (l + 7) / 8;
    bit acc;
    bit r8_ok = 1'b1;
    for (int j = 0; j < n; j++) begin
      int w = 0;
      int edlc = (j == n - 1) ? (l - 8 * (n - 1)) : 8;
      forever begin
        frm_ready = rdy_fn(mode, w);
        if (frm_valid) begin
          bit match = (frm_id == exp_id(m, n, j)) && (frm_dlc == 4'(edlc)) &&
                      (frm_data == exp_data(m, l, j));
          if (in_ready) r8_ok = 1'b0;
          if (!frm_ready && !match)
            chk(1'b0, "R5 stalled frame changed", 64'(frm_id), 64'(exp_id(m, n, j)));
          if (frm_ready) begin
            chk(frm_id == exp_id(m, n, j), "R2 R3 frame id", 64'(frm_id), 64'(exp_id(m, n, j)));
            chk(frm_dlc == 4'(edlc), "R4 frame dlc", 64'(frm_dlc), 64'(edlc));
            chk(frm_data == exp_data(m, l, j), "R1 R4 frame data", frm_data, exp_data(m, l, j));
          end
        end
        acc = frm_valid && frm_ready;
        @(posedge clk); @(negedge clk);
        w++;
        if (acc) break;
      end
    end
    frm_ready = 1'b0;
    chk(busy == 1'b0 && frm_valid == 1'b0, "R6 busy after final frame",
        64'({busy, frm_valid}), 64'd0);
    chk(r8_ok, "R8 in_ready while frame offered", 64'(r8_ok), 64'd1);
  endtask

  task automatic run_msg(input int m, input int l, input int mode);
    @(negedge clk);
    msg_start = 1'b1;
    msg_len   = 7'(l);
    msg_id    = mid(m);
    @(posedge clk); @(negedge clk);
    msg_start = 1'b0;
    chk(busy == 1'b1 && err == 1'b0, "R6 busy after start", 64'({busy, err}), 64'h2);
    fork
      produce(m, l, mode);
      consume(m, l, mode);
    join
  endtask

  task automatic reject(input int l);
    @(negedge clk);
    msg_start = 1'b1;
    msg_len   = 7'(l);
    msg_id    = 29'h155;
    @(posedge clk); @(negedge clk);
    msg_start = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R7 reject pulse", 64'({err, busy}), 64'h2);
    @(posedge clk); @(negedge clk);
    chk(err == 1'b0 && in_ready == 1'b0 && frm_valid == 1'b0, "R7 reject one cycle no frame",
        64'({err, in_ready, frm_valid}), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(busy == 0 && err == 0 && frm_valid == 0 && in_ready == 0, "R10 in reset",
        64'({busy, err, frm_valid, in_ready}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && err == 0 && frm_valid == 0 && in_ready == 0, "R10 after reset",
        64'({busy, err, frm_valid, in_ready}), 64'd0);

    reject(0);
    reject(MAXL + 1);
    reject(127);

    for (int l = 1; l <= MAXL; l++) run_msg(l, l, l % 3);

    // R9: start coincides with the final frame's acceptance
    @(negedge clk);
    msg_start = 1'b1; msg_len = 7'd3; msg_id = mid(7);
    @(posedge clk); @(negedge clk);
    msg_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_byte = mbyte(7, i);
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0;
    chk(frm_valid == 1'b1 && frm_id == exp_id(7, 1, 0), "R9 frame waiting",
        64'(frm_id), 64'(exp_id(7, 1, 0)));
    frm_ready = 1'b1; msg_start = 1'b1; msg_len = 7'd5; msg_id = mid(9);
    @(posedge clk); @(negedge clk);
    frm_ready = 1'b0; msg_start = 1'b0;
    chk(busy == 1'b0 && err == 1'b0, "R9 start at final accept ignored",
        64'({busy, err}), 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0 && in_ready == 1'b0 && err == 1'b0, "R9 still idle",
        64'({busy, in_ready, err}), 64'd0);

    run_msg(200, 9, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule